// File: doc/BRIEF.md
# Correlating Two-Level Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a short register of the directions taken by the most recent resolved branches. That global history, joined with low-order bits of the branch address, selects one saturating counter in a flat table. In effect, each address row holds 2^HIST_W counters, and the recent global outcomes pick which one speaks for the branch. The default build uses 8 address bits, 2 history bits and 2-bit counters, for 1024 counters in total. With zero history bits the block becomes a plain per-address counter table.

The front end presents a branch address on the lookup port and reads back a taken or not-taken guess in the same cycle. The lookup path is purely combinational. When the branch resolves, the back end pulses the update port with the address and the real direction. On that clock edge the counter selected by the address and the current history moves one step, and the outcome is shifted into the history.

With 2-bit counters, each counter is a four-state machine. Its states are STRONG_NT (00), WEAK_NT (01), WEAK_T (10) and STRONG_T (11). A taken outcome moves one step: STRONG_NT to WEAK_NT, WEAK_NT to WEAK_T, WEAK_T to STRONG_T, and STRONG_T stays put. A not-taken outcome moves one step the other way: STRONG_T to WEAK_T, WEAK_T to WEAK_NT, WEAK_NT to STRONG_NT, and STRONG_NT stays put. The guess is taken in the two T states.

Top module: `bp_corr_top`

## Requirements
- R1: While reset is asserted and after it is released, every counter holds the weakly not-taken value (01 for 2-bit counters), so every lookup predicts not-taken, and the global history is all zeros.
- R2: The counter index is {address[PC_LSB+IDX_W-1:PC_LSB], history}, with the history in the low bits. No tag is checked, so addresses that agree in those bits share counters.
- R3: Each counter saturates at both ends. It steps up by one on a taken update and down by one on a not-taken update, and the prediction is its most significant bit (1 = taken).
- R4: A counter in a strong state needs two opposite outcomes to change the predicted direction. One opposite outcome leaves the prediction unchanged.
- R5: An update changes only the counter picked by the update address and the current history. Other counters of the same address row and of other rows keep their values.
- R6: Every valid update shifts its outcome into bit 0 of the history (1 = taken) on the same edge as the counter update. The older bits move up by one, and the oldest bit is dropped.
- R7: The lookup result is combinational in the lookup address. A lookup made in the same cycle as an update sees the state from before that update.
- R8: While up_valid is low, the counters and the history do not change, whatever up_pc and up_taken carry.
- R9: With HIST_W = 0, each address index owns exactly one counter, and the prediction does not depend on earlier outcomes of other branches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_pc | input | PC_W | Branch address to predict |
| lk_taken | output | 1 | Predicted direction, 1 = taken |
| up_valid | input | 1 | A resolved branch is reported this cycle |
| up_pc | input | PC_W | Address of the resolved branch |
| up_taken | input | 1 | Resolved direction, 1 = taken |

## Verification
The bench builds two copies of the block. The first uses the default 8 address bits, 2 history bits and 2-bit counters. With it, the bench steers the history to chosen values and so reaches one counter of an address row while the row's other counters stay untouched. It also drives aliasing addresses that lie 256 apart. The second copy uses 4 address bits and no history, which brings the plain-table reduction within reach, with aliasing every 16 addresses.

// File: rtl/bp_pkg.sv
package bp_pkg;

    // Named states of a 2-bit direction counter; the MSB is the guess.
    typedef enum logic [1:0] {
        C_STRONG_NT = 2'b00,
        C_WEAK_NT   = 2'b01,
        C_WEAK_T    = 2'b10,
        C_STRONG_T  = 2'b11
    } ctr2_e;

    // Next state of a 2-bit counter for one resolved outcome.
    function automatic ctr2_e ctr2_next(ctr2_e cur, logic taken);
        ctr2_e nxt;
        unique case (cur)
            C_STRONG_NT: nxt = taken ? C_WEAK_NT  : C_STRONG_NT;
            C_WEAK_NT:   nxt = taken ? C_WEAK_T   : C_STRONG_NT;
            C_WEAK_T:    nxt = taken ? C_STRONG_T : C_WEAK_NT;
            C_STRONG_T:  nxt = taken ? C_STRONG_T : C_WEAK_T;
            default:     nxt = C_WEAK_NT;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/bp_ghist.sv
module bp_ghist #(
    parameter  int HIST_W = 2,
    localparam int HW_EFF = (HIST_W > 0) ? HIST_W : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              shift_in,
    output logic [HW_EFF-1:0] hist
);

    generate
        if (HIST_W > 1) begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)        hist <= '0;
                else if (shift_en) hist <= {hist[HW_EFF-2:0], shift_in};
            end
        end else if (HIST_W == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)        hist <= '0;
                else if (shift_en) hist <= shift_in;
            end
        end else begin : g_none
            logic unused_shift;
            assign unused_shift = shift_en ^ shift_in;
            assign hist = '0;
        end

        if (HIST_W > 0) begin : g_chk
            // R6: the newest outcome lands in bit 0
            a_r6_newest_bit: assert property (@(posedge clk) disable iff (!rst_n)
                shift_en |=> hist[0] == $past(shift_in));
            // R8: no valid update, no history movement
            a_r8_hist_hold: assert property (@(posedge clk) disable iff (!rst_n)
                !shift_en |=> $stable(hist));
        end
    endgenerate

endmodule

// File: rtl/bp_index.sv
module bp_index #(
    parameter  int PC_W    = 32,
    parameter  int PC_LSB  = 0,
    parameter  int IDX_W   = 8,
    parameter  int HIST_W  = 2,
    localparam int HW_EFF  = (HIST_W > 0) ? HIST_W : 1,
    localparam int IDX_TOT = IDX_W + HIST_W
) (
    input  logic [PC_W-1:0]    pc,
    input  logic [HW_EFF-1:0]  hist,
    output logic [IDX_TOT-1:0] idx
);

    logic unused_bits;
    assign unused_bits = ^pc ^ ^hist;

    generate
        if (HIST_W > 0) begin : g_corr
            assign idx = {pc[PC_LSB+IDX_W-1:PC_LSB], hist};
        end else begin : g_flat
            assign idx = pc[PC_LSB+IDX_W-1:PC_LSB];
        end
    endgenerate

endmodule

// File: rtl/bp_ctr_table.sv
module bp_ctr_table
    import bp_pkg::*;
#(
    parameter  int IDX_TOT = 10,
    parameter  int CTR_W   = 2,
    localparam int DEPTH   = 1 << IDX_TOT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [IDX_TOT-1:0] rd_idx,
    output logic               rd_taken,
    input  logic               wr_en,
    input  logic [IDX_TOT-1:0] wr_idx,
    input  logic               wr_taken
);

    localparam logic [CTR_W-1:0] CTR_MAX  = '1;
    localparam logic [CTR_W-1:0] CTR_INIT = CTR_W'((1 << (CTR_W - 1)) - 1);

    logic [CTR_W-1:0] mem [DEPTH];
    logic [CTR_W-1:0] cur;
    logic [CTR_W-1:0] nxt;

    assign cur = mem[wr_idx];

    generate
        if (CTR_W == 2) begin : g_fsm
            always_comb nxt = ctr2_next(ctr2_e'(cur), wr_taken);
        end else begin : g_sat
            always_comb begin
                nxt = cur;
                if (wr_taken && cur != CTR_MAX)   nxt = cur + 1'b1;
                else if (!wr_taken && cur != '0)  nxt = cur - 1'b1;
            end
        end
    endgenerate

    // State register: all counters.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= CTR_INIT;
        end else if (wr_en) begin
            mem[wr_idx] <= nxt;
        end
    end

    // Output: guess is the counter MSB.
    always_comb rd_taken = mem[rd_idx][CTR_W-1];

    // Checker state: what the written counter and its neighbour held.
    logic               chk_v;
    logic               chk_dir;
    logic [IDX_TOT-1:0] chk_idx;
    logic [CTR_W-1:0]   chk_old;
    logic [CTR_W-1:0]   chk_nb_old;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_v      <= 1'b0;
            chk_dir    <= 1'b0;
            chk_idx    <= '0;
            chk_old    <= '0;
            chk_nb_old <= '0;
        end else begin
            chk_v      <= wr_en;
            chk_dir    <= wr_taken;
            chk_idx    <= wr_idx;
            chk_old    <= cur;
            chk_nb_old <= mem[wr_idx ^ IDX_TOT'(1)];
        end
    end

    // R3: a taken update moves up one step or stays at the top
    a_r3_step_up: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_v && chk_dir) |->
            ((chk_old == CTR_MAX) ? (mem[chk_idx] == CTR_MAX)
                                  : (mem[chk_idx] == chk_old + 1'b1)));
    // R3: a not-taken update moves down one step or stays at the bottom
    a_r3_step_down: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_v && !chk_dir) |->
            ((chk_old == '0) ? (mem[chk_idx] == '0)
                             : (mem[chk_idx] == chk_old - 1'b1)));
    // R5: the neighbouring counter is not touched by the write
    a_r5_neighbour_kept: assert property (@(posedge clk) disable iff (!rst_n)
        chk_v |-> mem[chk_idx ^ IDX_TOT'(1)] == chk_nb_old);

endmodule

// File: rtl/bp_corr_top.sv
module bp_corr_top #(
    parameter int PC_W   = 32,
    parameter int PC_LSB = 0,
    parameter int IDX_W  = 8,
    parameter int HIST_W = 2,
    parameter int CTR_W  = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] lk_pc,
    output logic            lk_taken,
    input  logic            up_valid,
    input  logic [PC_W-1:0] up_pc,
    input  logic            up_taken
);

    localparam int HW_EFF  = (HIST_W > 0) ? HIST_W : 1;
    localparam int IDX_TOT = IDX_W + HIST_W;

    logic [HW_EFF-1:0]  hist;
    logic [IDX_TOT-1:0] lk_idx;
    logic [IDX_TOT-1:0] up_idx;

    bp_ghist #(.HIST_W(HIST_W)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (up_valid),
        .shift_in (up_taken),
        .hist     (hist)
    );

    bp_index #(.PC_W(PC_W), .PC_LSB(PC_LSB), .IDX_W(IDX_W), .HIST_W(HIST_W)) u_lk_idx (
        .pc   (lk_pc),
        .hist (hist),
        .idx  (lk_idx)
    );

    bp_index #(.PC_W(PC_W), .PC_LSB(PC_LSB), .IDX_W(IDX_W), .HIST_W(HIST_W)) u_up_idx (
        .pc   (up_pc),
        .hist (hist),
        .idx  (up_idx)
    );

    bp_ctr_table #(.IDX_TOT(IDX_TOT), .CTR_W(CTR_W)) u_tbl (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (lk_idx),
        .rd_taken (lk_taken),
        .wr_en    (up_valid),
        .wr_idx   (up_idx),
        .wr_taken (up_taken)
    );

    // R7: with no update and a steady lookup address, the guess is steady
    a_r7_steady_guess: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(up_valid) && $stable(lk_pc)) |-> $stable(lk_taken));

endmodule

// File: tb/sim_bp_corr_top.sv
module sim_bp_corr_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lk_pc = '0;
    logic        lk_taken;
    logic        up_valid = 1'b0;
    logic [31:0] up_pc = '0;
    logic        up_taken = 1'b0;

    logic [31:0] lk1_pc = '0;
    logic        lk1_taken;
    logic        up1_valid = 1'b0;
    logic [31:0] up1_pc = '0;
    logic        up1_taken = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    int mdl [1024];
    int mhist;
    int mb [16];

    always #4 clk = ~clk;

    bp_corr_top u0 (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken),
        .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken)
    );

    bp_corr_top #(.IDX_W(4), .HIST_W(0)) u1 (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk1_pc), .lk_taken(lk1_taken),
        .up_valid(up1_valid), .up_pc(up1_pc), .up_taken(up1_taken)
    );

    task automatic chk(string req, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b", req, act, exp);
        end
    endtask

    function automatic logic mdl_guess(int pc);
        return mdl[((pc & 255) << 2) | mhist] >= 2;
    endfunction

    // Called right after a negedge; returns right after the next negedge.
    task automatic upd(int pc, bit t);
        int ix;
        up_valid = 1'b1; up_pc = pc; up_taken = t;
        @(posedge clk);
        ix = ((pc & 255) << 2) | mhist;
        if (t && mdl[ix] < 3) mdl[ix]++;
        if (!t && mdl[ix] > 0) mdl[ix]--;
        mhist = ((mhist << 1) | int'(t)) & 3;
        @(negedge clk);
        up_valid = 1'b0;
    endtask

    task automatic upd1(int pc, bit t);
        up1_valid = 1'b1; up1_pc = pc; up1_taken = t;
        @(posedge clk);
        if (t && mb[pc & 15] < 3) mb[pc & 15]++;
        if (!t && mb[pc & 15] > 0) mb[pc & 15]--;
        @(negedge clk);
        up1_valid = 1'b0;
    endtask

    task automatic probe(string req, int pc, logic exp);
        lk_pc = pc;
        #1;
        chk(req, lk_taken, exp);
        chk(req, lk_taken, mdl_guess(pc));
    endtask

    task automatic probe1(string req, int pc, logic exp);
        lk1_pc = pc;
        #1;
        chk(req, lk1_taken, exp);
        chk(req, lk1_taken, logic'(mb[pc & 15] >= 2));
    endtask

    task automatic t_reset;
        // R1: all counters weakly not-taken, history zero
        probe("R1", 32'h0, 1'b0);
        probe("R1", 32'h5, 1'b0);
        probe("R1", 32'hFF, 1'b0);
        probe("R1", 32'h3E8, 1'b0);
        probe1("R1", 32'h7, 1'b0);
    endtask

    task automatic t_hysteresis;
        for (int i = 0; i < 4; i++) upd(32'h10, 1'b1);
        probe("R3", 32'h10, 1'b1);
        upd(32'h10, 1'b0);
        upd(32'h20, 1'b1);
        upd(32'h20, 1'b1);
        probe("R4", 32'h10, 1'b1);      // one miss from strong: still taken
        upd(32'h10, 1'b0);
        upd(32'h20, 1'b1);
        upd(32'h20, 1'b1);
        probe("R4", 32'h10, 1'b0);      // second miss flips
    endtask

    task automatic t_select;
        for (int i = 0; i < 3; i++) upd(32'h30, 1'b1);
        probe("R5", 32'h30, 1'b1);
        upd(32'h40, 1'b0);
        upd(32'h40, 1'b0);
        probe("R5", 32'h30, 1'b0);      // history 00: other counter untouched
        upd(32'h40, 1'b1);
        probe("R6", 32'h30, 1'b0);      // history 01
        upd(32'h40, 1'b1);
        probe("R6", 32'h30, 1'b1);      // history 11 again
    endtask

    task automatic t_alias;
        probe("R2", 32'h130, 1'b1);     // same low 8 bits as 0x30
        probe("R2", 32'h31, 1'b0);
    endtask

    task automatic t_same_cycle;
        up_valid = 1'b1; up_pc = 32'h50; up_taken = 1'b1; lk_pc = 32'h50;
        #1;
        chk("R7", lk_taken, 1'b0);      // old state seen before the edge
        up_valid = 1'b0;
        upd(32'h50, 1'b1);
        probe("R7", 32'h50, 1'b1);
    endtask

    task automatic t_ignore;
        for (int i = 0; i < 4; i++) begin
            up_valid = 1'b0; up_pc = 32'h50; up_taken = i[0];
            @(negedge clk);
        end
        probe("R8", 32'h50, 1'b1);
        probe("R8", 32'h30, 1'b1);      // history still 11
        probe("R8", 32'h10, 1'b0);
    endtask

    task automatic t_mixed;
        logic [15:0] lf = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            upd(int'(lf & 16'h0307), lf[4] | lf[9]);
            lk_pc = int'({lf[7:0], lf[15:8]} & 16'h0307);
            #1;
            chk("R2 R3 R6", lk_taken, mdl_guess(int'(lk_pc)));
        end
    endtask

    task automatic t_flat;
        for (int i = 0; i < 3; i++) upd1(32'h3, 1'b1);
        probe1("R9", 32'h3, 1'b1);
        upd1(32'h5, 1'b0);
        upd1(32'h5, 1'b1);
        probe1("R9", 32'h3, 1'b1);      // other outcomes change nothing
        upd1(32'h3, 1'b0);
        probe1("R9", 32'h3, 1'b1);
        upd1(32'h13, 1'b0);             // aliases with 0x3
        probe1("R9", 32'h3, 1'b0);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mdl[i] = 1;
        for (int i = 0; i < 16; i++) mb[i] = 1;
        mhist = 0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_hysteresis();
        t_select();
        t_alias();
        t_same_cycle();
        t_ignore();
        t_mixed();
        t_flat();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule